// File: doc/BRIEF.md
# Dual-Match Down-Counting Timer Channel

One channel of a general-purpose timer. While enabled, a counter runs down from a programmable reload value to zero, then starts again from the reload value. Each count step is either one bus clock cycle or one pulse of a 1 MHz tick enable. The tick enable is a single-cycle strobe that is synchronous to the bus clock. Two match registers mark points inside each countdown period, and zero marks a third. Each time the count reaches one of these event points, the interrupt line inverts and a one-cycle status pulse is raised.

The channel sits behind a bus decoder that is not part of this block. The decoder supplies the channel's four control bits and a write strobe for each of the count, reload and two match registers, all sharing one write-data bus. The channel returns the visible count, the stored registers and the registered control bits. A match value at or above the reload value cannot be reached in the period, so it is folded to zero. A reload value shorter than 20 microseconds of count steps is raised to that minimum. The pulse-enable bit is stored and reported, but no pulse waveform is generated.

Top module: `timer_chan`

## Requirements
- R1: With enable set and the clock-select bit clear, the live count falls by exactly one on every bus clock cycle while it is nonzero and no register write is present.
- R2: A count step taken at zero loads the reload value instead of decrementing.
- R3: A match register whose value is greater than or equal to the reload value is treated as zero, so no event ever fires at its stored value.
- R4: An event fires on the step where the count reaches a nonzero folded match value. Within a period the events come at the larger match, then the smaller match, then zero.
- R5: The step that reaches zero is an event only if the overflow-interrupt bit is set or either raw match register holds zero.
- R6: Each event inverts irq_o and drives evt_o high for exactly one cycle, on the same edge at which count_o shows the event value. irq_o never changes otherwise.
- R7: While the channel is disabled, count_o equals reload_o.
- R8: A written reload value below the ticks in 20 microseconds is stored as that minimum. The minimum is BUS_MHZ*20 (480 by default) when the clock-select bit is 0, and 20 when it is 1.
- R9: With the clock-select bit set, the count changes only on cycles where tick_1mhz_i is high.
- R10: A count-register write while enabled makes count_o show the written value after the next edge. While disabled, such a write has no effect.
- R11: A reload write while enabled, with the stored reload at zero, loads the count with the written value. Otherwise a reload write leaves the count alone.
- R12: Raising enable restarts the count from the reload value. With enable clear, no event fires and the count is frozen.
- R13: Reset clears the count, reload, both matches, irq_o, evt_o and ctrl_o. The ctrl_o bits are: bit 0 enable, bit 1 clock select (1 = tick), bit 2 overflow-interrupt enable, bit 3 pulse enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_1mhz_i | input | 1 | Single-cycle 1 MHz tick enable |
| ctl_en_i | input | 1 | Channel enable |
| ctl_ext_clk_i | input | 1 | Count-source select, 1 = tick enable |
| ctl_ovf_ie_i | input | 1 | Event at zero enable |
| ctl_pulse_en_i | input | 1 | Pulse-mode enable, stored only |
| cnt_we_i | input | 1 | Count register write strobe |
| reload_we_i | input | 1 | Reload register write strobe |
| match0_we_i | input | 1 | First match register write strobe |
| match1_we_i | input | 1 | Second match register write strobe |
| wdata_i | input | CNT_W | Write data |
| count_o | output | CNT_W | Live count when enabled, reload when disabled |
| reload_o | output | CNT_W | Stored reload value |
| match0_o | output | CNT_W | Stored first match value |
| match1_o | output | CNT_W | Stored second match value |
| ctrl_o | output | 4 | Registered control bits |
| irq_o | output | 1 | Interrupt level, toggles per event |
| evt_o | output | 1 | One-cycle status pulse per event |

## Verification
The assertions check the following on every cycle:
- the count decrements by one on the bus clock and wraps to the reload value;
- the count holds between ticks when the tick source is selected;
- the reload floor is respected;
- every event lands on a legal point (a stored match below the reload value, or zero with a qualifying condition);
- irq_o moves only together with evt_o, and no event fires while disabled.

The ordering of events inside a period, the folding of out-of-range matches, and the handling of count and reload writes can only be shown by the bench's scenarios. The same holds for the restart on enable and the exact timing of the tick-driven count. The bench covers these with a behavioural reference model compared on every clock, plus logs of the count values at which events fire.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef struct packed {
    logic pulse_en;
    logic ovf_ie;
    logic ext_clk;
    logic en;
  } tmr_ctl_t;

  localparam int unsigned NUM_MATCH = 2;
  localparam int unsigned MIN_US    = 20;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned MIN_BUS = 480,
  parameter int unsigned MIN_EXT = 20
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic                                      ext_clk_i,
  input  logic                                      reload_we_i,
  input  logic [tmr_pkg::NUM_MATCH-1:0]             match_we_i,
  input  logic [CNT_W-1:0]                          wdata_i,
  output logic [CNT_W-1:0]                          reload_o,
  output logic [tmr_pkg::NUM_MATCH-1:0][CNT_W-1:0]  match_o
);
  logic [CNT_W-1:0] floor_w;
  logic [CNT_W-1:0] reload_d;

  // floor depends on the count source in force at write time
  assign floor_w  = ext_clk_i ? CNT_W'(MIN_EXT) : CNT_W'(MIN_BUS);
  assign reload_d = (wdata_i < floor_w) ? floor_w : wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          reload_o <= '0;
    else if (reload_we_i) reload_o <= reload_d;
  end

  for (genvar i = 0; i < tmr_pkg::NUM_MATCH; i++) begin : g_match
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            match_o[i] <= '0;
      else if (match_we_i[i]) match_o[i] <= wdata_i;
    end
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ext_clk_i,
  input  logic             tick_i,
  input  logic             cnt_we_i,
  input  logic             reload_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             en_q_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dec_o,
  output logic [CNT_W-1:0] cnt_next_o
);
  logic rise, step, load_wr;

  assign rise       = en_i & ~en_q_o;
  assign step       = en_i & en_q_o & (ext_clk_i ? tick_i : 1'b1);
  // a first reload write into an empty reload also seeds the count
  assign load_wr    = en_q_o & (cnt_we_i | (reload_we_i & (reload_i == '0)));
  assign cnt_next_o = cnt_o - CNT_W'(1);
  assign dec_o      = step & ~load_wr & (cnt_o != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q_o <= 1'b0;
      cnt_o  <= '0;
    end else begin
      en_q_o <= en_i;
      if (rise)              cnt_o <= reload_i;
      else if (load_wr)      cnt_o <= wdata_i;
      else if (step) begin
        if (cnt_o == '0)     cnt_o <= reload_i;
        else                 cnt_o <= cnt_next_o;
      end
    end
  end
endmodule

// File: rtl/tmr_event.sv
module tmr_event #(
  parameter int unsigned CNT_W = 32
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic                                      dec_i,
  input  logic [CNT_W-1:0]                          cnt_next_i,
  input  logic [CNT_W-1:0]                          reload_i,
  input  logic [tmr_pkg::NUM_MATCH-1:0][CNT_W-1:0]  match_i,
  input  logic                                      ovf_ie_i,
  output logic                                      evt_o,
  output logic                                      irq_o
);
  logic [tmr_pkg::NUM_MATCH-1:0] hit, raw_zero;
  logic at_zero, fire;

  for (genvar i = 0; i < tmr_pkg::NUM_MATCH; i++) begin : g_cmp
    logic [CNT_W-1:0] folded;
    // unreachable match points collapse onto zero
    assign folded      = (match_i[i] >= reload_i) ? '0 : match_i[i];
    assign hit[i]      = (folded != '0) && (cnt_next_i == folded);
    assign raw_zero[i] = (match_i[i] == '0);
  end

  assign at_zero = (cnt_next_i == '0) & (ovf_ie_i | (|raw_zero));
  assign fire    = dec_i & ((|hit) | at_zero);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      evt_o <= fire;
      if (fire) irq_o <= ~irq_o;
    end
  end
endmodule

// File: rtl/timer_chan.sv
module timer_chan #(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned BUS_MHZ  = 24,
  parameter int unsigned TICK_MHZ = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_1mhz_i,
  input  logic             ctl_en_i,
  input  logic             ctl_ext_clk_i,
  input  logic             ctl_ovf_ie_i,
  input  logic             ctl_pulse_en_i,
  input  logic             cnt_we_i,
  input  logic             reload_we_i,
  input  logic             match0_we_i,
  input  logic             match1_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] reload_o,
  output logic [CNT_W-1:0] match0_o,
  output logic [CNT_W-1:0] match1_o,
  output logic [3:0]       ctrl_o,
  output logic             irq_o,
  output logic             evt_o
);
  import tmr_pkg::*;

  localparam int unsigned MIN_BUS = BUS_MHZ * MIN_US;
  localparam int unsigned MIN_EXT = TICK_MHZ * MIN_US;

  logic [NUM_MATCH-1:0][CNT_W-1:0] match_q;
  logic [CNT_W-1:0] cnt_q, cnt_next;
  logic             en_q, dec;
  tmr_ctl_t         ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q.pulse_en <= 1'b0;
      ctl_q.ovf_ie   <= 1'b0;
      ctl_q.ext_clk  <= 1'b0;
    end else begin
      ctl_q.pulse_en <= ctl_pulse_en_i;
      ctl_q.ovf_ie   <= ctl_ovf_ie_i;
      ctl_q.ext_clk  <= ctl_ext_clk_i;
    end
  end
  assign ctl_q.en = en_q;

  tmr_regs #(.CNT_W(CNT_W), .MIN_BUS(MIN_BUS), .MIN_EXT(MIN_EXT)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_clk_i  (ctl_ext_clk_i),
    .reload_we_i(reload_we_i),
    .match_we_i ({match1_we_i, match0_we_i}),
    .wdata_i    (wdata_i),
    .reload_o   (reload_o),
    .match_o    (match_q)
  );

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ctl_en_i),
    .ext_clk_i  (ctl_ext_clk_i),
    .tick_i     (tick_1mhz_i),
    .cnt_we_i   (cnt_we_i),
    .reload_we_i(reload_we_i),
    .wdata_i    (wdata_i),
    .reload_i   (reload_o),
    .en_q_o     (en_q),
    .cnt_o      (cnt_q),
    .dec_o      (dec),
    .cnt_next_o (cnt_next)
  );

  tmr_event #(.CNT_W(CNT_W)) u_event (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dec_i     (dec),
    .cnt_next_i(cnt_next),
    .reload_i  (reload_o),
    .match_i   (match_q),
    .ovf_ie_i  (ctl_ovf_ie_i),
    .evt_o     (evt_o),
    .irq_o     (irq_o)
  );

  assign count_o  = en_q ? cnt_q : reload_o;
  assign match0_o = match_q[0];
  assign match1_o = match_q[1];
  assign ctrl_o   = ctl_q;
endmodule

// File: rtl/timer_chan_chk.sv
module timer_chan_chk #(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned TICK_MHZ = 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_1mhz_i,
  input logic             ctl_en_i,
  input logic             ctl_ext_clk_i,
  input logic             cnt_we_i,
  input logic             reload_we_i,
  input logic             match0_we_i,
  input logic             match1_we_i,
  input logic             en_q_i,
  input logic             ovf_q_i,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] reload_o,
  input logic [CNT_W-1:0] match0_o,
  input logic [CNT_W-1:0] match1_o,
  input logic             irq_o,
  input logic             evt_o
);
  localparam int unsigned MIN_EXT = TICK_MHZ * tmr_pkg::MIN_US;

  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  // R1
  bus_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q_i && ctl_en_i && !ctl_ext_clk_i && !cnt_we_i && !reload_we_i && count_o != '0)
    |=> count_o == $past(count_o) - CNT_W'(1));

  // R2
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q_i && ctl_en_i && !ctl_ext_clk_i && !cnt_we_i && !reload_we_i && count_o == '0)
    |=> count_o == $past(reload_o));

  // R3
  fold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && evt_o && count_o != '0 && !$past(reload_we_i)) |-> count_o < reload_o);

  // R4
  match_point_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && evt_o && count_o != '0 && !$past(match0_we_i) && !$past(match1_we_i))
    |-> (count_o == match0_o || count_o == match1_o));

  // R5
  zero_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && evt_o && count_o == '0 && !$past(match0_we_i) && !$past(match1_we_i))
    |-> (ovf_q_i || match0_o == '0 || match1_o == '0));

  // R6
  irq_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && evt_o) |-> irq_o != $past(irq_o));

  // R6
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !evt_o) |-> irq_o == $past(irq_o));

  // R8
  reload_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_o == '0 || reload_o >= CNT_W'(MIN_EXT));

  // R9
  tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q_i && ctl_en_i && ctl_ext_clk_i && !tick_1mhz_i && !cnt_we_i && !reload_we_i)
    |=> $stable(count_o));

  // R12
  no_evt_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> en_q_i);

  // R12
  frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q_i && !ctl_en_i && !reload_we_i) |=> $stable(count_o));
endmodule

bind timer_chan timer_chan_chk #(.CNT_W(CNT_W), .TICK_MHZ(TICK_MHZ)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_1mhz_i  (tick_1mhz_i),
  .ctl_en_i     (ctl_en_i),
  .ctl_ext_clk_i(ctl_ext_clk_i),
  .cnt_we_i     (cnt_we_i),
  .reload_we_i  (reload_we_i),
  .match0_we_i  (match0_we_i),
  .match1_we_i  (match1_we_i),
  .en_q_i       (ctrl_o[0]),
  .ovf_q_i      (ctrl_o[2]),
  .count_o      (count_o),
  .reload_o     (reload_o),
  .match0_o     (match0_o),
  .match1_o     (match1_o),
  .irq_o        (irq_o),
  .evt_o        (evt_o)
);

// File: tb/tb_timer_chan.sv
module tb_timer_chan;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int MIN_BUS = 24 * 20;
  localparam int MIN_EXT = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, en = 1'b0, ext = 1'b0, ovf = 1'b0, pls = 1'b0;
  logic cnt_we = 1'b0, rel_we = 1'b0, m0_we = 1'b0, m1_we = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] count_o, reload_o, match0_o, match1_o;
  logic [3:0] ctrl_o;
  logic irq_o, evt_o;

  int n_chk = 0, n_fail = 0, cycles = 0, tick_per = 1, tick_div = 0;
  int ev_q[$];
  int toggles = 0, events = 0;
  logic prev_irq = 1'b0;

  // reference model state
  longint m_cnt = 0, m_rel = 0, m_m0 = 0, m_m1 = 0;
  bit m_en = 0, m_irq = 0, m_evt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  timer_chan dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_1mhz_i(tick), .ctl_en_i(en),
    .ctl_ext_clk_i(ext), .ctl_ovf_ie_i(ovf), .ctl_pulse_en_i(pls),
    .cnt_we_i(cnt_we), .reload_we_i(rel_we), .match0_we_i(m0_we),
    .match1_we_i(m1_we), .wdata_i(wdata), .count_o(count_o),
    .reload_o(reload_o), .match0_o(match0_o), .match1_o(match1_o),
    .ctrl_o(ctrl_o), .irq_o(irq_o), .evt_o(evt_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    #2;
    tick_div = (tick_div + 1) % tick_per;
    tick = (tick_div == 0);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  // behavioural reference, updated at each edge from the stable inputs
  always @(posedge clk or negedge rst_n) begin : mdl
    bit rise, stp, ld, ev;
    longint nc, f0, f1, fl, nr;
    if (!rst_n) begin
      m_cnt = 0; m_rel = 0; m_m0 = 0; m_m1 = 0; m_en = 0; m_irq = 0; m_evt = 0;
    end else begin
      rise = en && !m_en;
      stp  = en && m_en && (ext ? tick : 1'b1);
      ld   = m_en && (cnt_we || (rel_we && m_rel == 0));
      fl   = ext ? MIN_EXT : MIN_BUS;
      nr   = rel_we ? ((wdata < fl) ? fl : wdata) : m_rel;
      ev   = 0;
      nc   = m_cnt;
      if (rise) nc = m_rel;
      else if (ld) nc = wdata;
      else if (stp) begin
        if (m_cnt == 0) nc = m_rel;
        else begin
          nc = m_cnt - 1;
          f0 = (m_m0 >= m_rel) ? 0 : m_m0;
          f1 = (m_m1 >= m_rel) ? 0 : m_m1;
          ev = (nc != 0 && (nc == f0 || nc == f1)) ||
               (nc == 0 && (ovf || m_m0 == 0 || m_m1 == 0));
        end
      end
      if (m0_we) m_m0 = wdata;
      if (m1_we) m_m1 = wdata;
      m_irq = m_irq ^ ev;
      m_evt = ev;
      m_en  = en;
      m_cnt = nc;
      m_rel = nr;
    end
  end

  // per-cycle comparison away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(count_o == (m_en ? m_cnt : m_rel), "R1 count model", count_o, m_en ? m_cnt : m_rel);
      chk(irq_o == m_irq, "R6 irq model", irq_o, m_irq);
      chk(evt_o == m_evt, "R4 evt model", evt_o, m_evt);
      chk(reload_o == m_rel, "R8 reload model", reload_o, m_rel);
      if (evt_o) begin ev_q.push_back(int'(count_o)); events++; end
      if (irq_o != prev_irq) toggles++;
      prev_irq = irq_o;
    end
  end

  task automatic wr(input int which, input longint v);
    @(posedge clk); #2;
    wdata = v[W-1:0];
    case (which)
      0: cnt_we = 1; 1: rel_we = 1; 2: m0_we = 1; default: m1_we = 1;
    endcase
    @(posedge clk); #2;
    cnt_we = 0; rel_we = 0; m0_we = 0; m1_we = 0;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    longint a, b;
    bit all_ok;
    run(3);
    rst_n = 1;
    @(negedge clk);
    // R13 reset state
    chk(count_o == 0 && reload_o == 0 && match0_o == 0 && match1_o == 0,
        "R13 regs", count_o | reload_o, 0);
    chk(irq_o == 0 && evt_o == 0 && ctrl_o == 0, "R13 flags", {irq_o, evt_o, ctrl_o}, 0);

    // R8 clamp on bus clock, R7 disabled readback
    wr(1, 100); @(negedge clk);
    chk(reload_o == MIN_BUS, "R8 bus floor", reload_o, MIN_BUS);
    chk(count_o == reload_o, "R7 disabled count", count_o, reload_o);
    ext = 1;
    wr(1, 5); @(negedge clk);
    chk(reload_o == MIN_EXT, "R8 tick floor", reload_o, MIN_EXT);
    wr(1, 600); @(negedge clk);
    chk(reload_o == 600, "R8 no clamp", reload_o, 600);

    // R4 order, R5 zero via overflow enable
    ext = 0; ovf = 1;
    wr(2, 400); wr(3, 200);
    ev_q.delete(); events = 0; toggles = 0;
    en = 1;
    run(1300);
    chk(ev_q.size() >= 6, "R4 event count", ev_q.size(), 6);
    if (ev_q.size() >= 6) begin
      chk(ev_q[0] == 400 && ev_q[3] == 400, "R4 larger first", ev_q[0], 400);
      chk(ev_q[1] == 200 && ev_q[4] == 200, "R4 smaller second", ev_q[1], 200);
      chk(ev_q[2] == 0 && ev_q[5] == 0, "R5 zero via ovf", ev_q[2], 0);
    end
    chk(toggles == events, "R6 toggles per event", toggles, events);
    // R2 wrap
    @(negedge clk);
    while (count_o != 0) @(negedge clk);
    @(negedge clk);
    chk(count_o == 600, "R2 wrap", count_o, 600);

    // R3 folding: above and equal to reload
    #1; ovf = 0;
    wr(2, 700);
    ev_q.delete();
    run(1300);
    all_ok = 1;
    foreach (ev_q[i]) if (ev_q[i] != 200) all_ok = 0;
    chk(all_ok && ev_q.size() >= 2, "R3 fold above", ev_q.size(), 2);
    wr(2, 600);
    ev_q.delete();
    run(700);
    all_ok = 1;
    foreach (ev_q[i]) if (ev_q[i] != 200) all_ok = 0;
    chk(all_ok && ev_q.size() >= 1, "R3 fold equal", ev_q.size(), 1);

    // R5 zero event from a raw zero match
    wr(3, 0);
    ev_q.delete();
    run(700);
    all_ok = 1;
    foreach (ev_q[i]) if (ev_q[i] != 0) all_ok = 0;
    chk(all_ok && ev_q.size() >= 1, "R5 raw zero match", ev_q.size(), 1);

    // R10 count write, R9 tick source
    ext = 1; tick_per = 3;
    wr(0, 300); @(negedge clk);
    chk(count_o == 300, "R10 count write", count_o, 300);
    a = count_o;
    repeat (30) @(negedge clk);
    b = count_o;
    chk(a - b == 10, "R9 tick rate", a - b, 10);

    // R10 ignored while disabled, R12 restart and freeze
    #1; ext = 0; tick_per = 1; en = 0;
    run(3);
    wr(0, 77); @(negedge clk);
    chk(count_o == 600, "R10 disabled write", count_o, 600);
    #1; en = 1;
    @(negedge clk); @(negedge clk);
    chk(count_o == 599, "R12 restart", count_o, 599);
    #1; en = 0;
    ev_q.delete();
    run(1000); @(negedge clk);
    chk(ev_q.size() == 0 && count_o == 600, "R12 frozen", ev_q.size(), 0);

    // R11 first reload write seeds the count
    rst_n = 0; run(2); rst_n = 1;
    en = 1; run(5);
    wr(1, 1000); @(negedge clk);
    chk(count_o == 1000, "R11 seed", count_o, 1000);
    wr(1, 700); @(negedge clk);
    chk(count_o == 998, "R11 no reseed", count_o, 998);
    chk(reload_o == 700, "R11 reload stored", reload_o, 700);

    run(5);
    finish_run();
  end
endmodule